// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a simplified two-wire serial EEPROM target with a 256-byte array. It has no real open-drain bus. A host register hands it one sample of the clock level and the data level each time the update strobe is high. The block replies with a single data level, which the host reads back. That level is the last data sample the target stored, or a low or array bit that the target put in place of it.

Each transfer opens with a start condition. The target then collects an 8-bit command and an 8-bit word address, both most significant bit first. It inserts an acknowledge slot after each of the two bytes. When the address byte completes, the target loads the addressed byte into its data register. If the command's low bit marks a read, the next transfer's address phase shifts that byte out on the returned data level.

A separate synchronous port writes the array contents before use.

Top module: `twire_eeprom_target`

## Requirements
- R1: Reset puts the stored clock and data samples high, the returned level at 1, the bit position at 0, and clears the command, address, data register and pending acknowledge. After reset, no bit is taken until a start condition.
- R2: A start condition is an update where the clock is high in both the stored and the new sample and the data falls. It sets the bit position to 1 and clears the command. A stop condition is the same but with the data rising. A stop changes neither the bit position nor the command, so the transfer continues counting after it.
- R3: While the bit position is 0 and no acknowledge is pending, every update other than a start or stop condition is ignored, and the returned level simply follows the host data.
- R4: A bit is taken only on a clock rising update: stored clock 0 and new clock 1, with the new data equal to the stored data. A rising update with differing data takes no bit.
- R5: A rising update while an acknowledge is pending makes the returned level 0 for that update and clears the pending flag.
- R6: Bits at positions 1 to 8 shift into the command register, most significant bit first. After the eighth, an acknowledge becomes pending. The command's bit 0, which is the last bit received, selects read (1) or write (0).
- R7: Bits at positions 9 to 16 shift into the word address, most significant bit first. After the eighth address bit, the array byte at that address loads into the data register, an acknowledge becomes pending, and the bit position returns to 0.
- R8: In the address phase of a read command, each taken bit returns the data register's most significant bit, and the data register then shifts left by one. Under a write command, the returned level follows the host data.
- R9: Outside acknowledge and read slots, the returned level equals the data level of the most recent update.
- R10: An init write (enable high, address, byte) stores the byte in the array on the clock edge. A later address phase that ends at that address loads it.
- R11: When the update strobe is low, the stored samples, the bit position and the pending acknowledge do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | Qualifies one clock/data sample pair |
| upd_scl | input | 1 | Sampled clock level from the host |
| upd_sda | input | 1 | Sampled data level from the host |
| sda_level | output | 1 | Returned data level (last stored sample) |
| init_en | input | 1 | Array init write enable |
| init_addr | input | 8 | Array init write address |
| init_byte | input | 8 | Array init write data |

## Verification
The bound checker watches the following on every cycle:
- a start condition resets the bit position and clears the command;
- the hunting state holds until a start;
- a pending acknowledge drives a low and is released on the next rising update;
- a mismatched rising update leaves the count unchanged;
- each phase ends at the right position with the acknowledge raised;
- nothing moves while the strobe is low.

Some behaviour can only be shown by the bench's scenarios. These are:
- the serial value of a read, as an array byte appears bit by bit in the following transfer;
- init-port contents reaching the bus;
- a stop condition that leaves the count running;
- the position at which an acknowledge appears after a restart or a rejected bit.

// File: rtl/twe_pkg.sv
package twe_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;

    // One clock/data sample pair as seen on the bus
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    // Classification of one update against the stored sample
    typedef enum logic [2:0] {
        EV_NONE,   // nothing to do (clock steady or falling)
        EV_START,  // data fell with clock high
        EV_STOP,   // data rose with clock high
        EV_HUNT,   // idle, waiting for a start
        EV_ACK,    // rising edge consumed by a pending acknowledge
        EV_BIT,    // rising edge with stable data: take a bit
        EV_SLIP    // rising edge with data changed: rejected
    } bus_ev_e;

    function automatic logic clk_rose(line_t prev, line_t cur);
        return !prev.scl && cur.scl;
    endfunction

    function automatic logic bus_cond(line_t prev, line_t cur);
        return prev.scl && cur.scl && (prev.sda != cur.sda);
    endfunction

endpackage

// File: rtl/twe_event_decode.sv
module twe_event_decode
    import twe_pkg::*;
(
    input  line_t   held,
    input  line_t   cur,
    input  logic    tick_zero,
    input  logic    ack_pend,
    output bus_ev_e ev
);

    always_comb begin
        ev = EV_NONE;
        if (bus_cond(held, cur)) begin
            ev = cur.sda ? EV_STOP : EV_START;
        end else if (tick_zero && !ack_pend) begin
            ev = EV_HUNT;
        end else if (clk_rose(held, cur)) begin
            if (ack_pend) begin
                ev = EV_ACK;
            end else if (held.sda == cur.sda) begin
                ev = EV_BIT;
            end else begin
                ev = EV_SLIP;
            end
        end
    end

endmodule

// File: rtl/twe_array.sv
module twe_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_byte
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_byte;
        end
    end

    assign rd_byte = mem[rd_addr];

endmodule

// File: rtl/twe_sequencer.sv
module twe_sequencer
    import twe_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 8,
    parameter int TW       = 5,
    parameter int CMD_END  = 9,
    parameter int ADDR_END = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  line_t         cur,
    input  bus_ev_e       ev,
    input  logic [DW-1:0] rd_byte,
    output line_t         held,
    output logic [AW-1:0] rd_addr,
    output logic [TW-1:0] tick,
    output logic          ack,
    output logic [DW-1:0] cmd
);

    localparam logic [TW-1:0] T_ONE       = TW'(1);
    localparam logic [TW-1:0] T_CMD_END   = TW'(CMD_END);
    localparam logic [TW-1:0] T_CMD_LAST  = TW'(CMD_END - 1);
    localparam logic [TW-1:0] T_ADDR_END  = TW'(ADDR_END);
    localparam logic [TW-1:0] T_ADDR_LAST = TW'(ADDR_END - 1);

    line_t          held_q, held_d;
    logic [TW-1:0]  tick_q, tick_d;
    logic [DW-1:0]  cmd_q,  cmd_d;
    logic [DW-1:0]  data_q, data_d;
    logic [AW-1:0]  addr_q, addr_d;
    logic           ack_q,  ack_d;
    logic [AW-1:0]  addr_shift;

    assign addr_shift = {addr_q[AW-2:0], cur.sda};
    assign rd_addr    = addr_shift;

    always_comb begin
        held_d = held_q;
        tick_d = tick_q;
        cmd_d  = cmd_q;
        data_d = data_q;
        addr_d = addr_q;
        ack_d  = ack_q;
        if (upd) begin
            held_d = cur;
            case (ev)
                EV_START: begin
                    tick_d = T_ONE;
                    cmd_d  = '0;
                end
                EV_ACK: begin
                    ack_d      = 1'b0;
                    held_d.sda = 1'b0;
                end
                EV_BIT: begin
                    if (tick_q < T_CMD_END) begin
                        // command phase
                        cmd_d  = {cmd_q[DW-2:0], cur.sda};
                        tick_d = tick_q + T_ONE;
                        if (tick_q == T_CMD_LAST) begin
                            ack_d = 1'b1;
                        end
                    end else if (tick_q < T_ADDR_END) begin
                        // address phase, read data shifts out
                        if (cmd_q[0]) begin
                            held_d.sda = data_q[DW-1];
                        end
                        addr_d = addr_shift;
                        data_d = {data_q[DW-2:0], 1'b0};
                        if (tick_q == T_ADDR_LAST) begin
                            data_d = rd_byte;
                            ack_d  = 1'b1;
                            tick_d = '0;
                        end else begin
                            tick_d = tick_q + T_ONE;
                        end
                    end else begin
                        held_d.sda = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '{scl: 1'b1, sda: 1'b1};
            tick_q <= '0;
            cmd_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            held_q <= held_d;
            tick_q <= tick_d;
            cmd_q  <= cmd_d;
            data_q <= data_d;
            addr_q <= addr_d;
            ack_q  <= ack_d;
        end
    end

    assign held = held_q;
    assign tick = tick_q;
    assign ack  = ack_q;
    assign cmd  = cmd_q;

endmodule

// File: rtl/twire_eeprom_target.sv
module twire_eeprom_target
    import twe_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int AWID   = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_stb,
    input  logic              upd_scl,
    input  logic              upd_sda,
    output logic              sda_level,
    input  logic              init_en,
    input  logic [AWID-1:0]   init_addr,
    input  logic [DATA_W-1:0] init_byte
);

    localparam int CMD_END  = DATA_W + 1;
    localparam int ADDR_END = CMD_END + AWID;
    localparam int TICK_W   = $clog2(ADDR_END + 1);

    line_t              cur_w;
    line_t              held_w;
    bus_ev_e            ev_w;
    logic [TICK_W-1:0]  tick_w;
    logic               ack_w;
    logic [DATA_W-1:0]  cmd_w;
    logic [AWID-1:0]    rd_addr_w;
    logic [DATA_W-1:0]  rd_byte_w;
    logic               held_scl_w;

    assign cur_w      = '{scl: upd_scl, sda: upd_sda};
    assign held_scl_w = held_w.scl;
    assign sda_level  = held_w.sda;

    twe_event_decode u_decode (
        .held      (held_w),
        .cur       (cur_w),
        .tick_zero (tick_w == '0),
        .ack_pend  (ack_w),
        .ev        (ev_w)
    );

    twe_sequencer #(
        .DW       (DATA_W),
        .AW       (AWID),
        .TW       (TICK_W),
        .CMD_END  (CMD_END),
        .ADDR_END (ADDR_END)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd_stb),
        .cur     (cur_w),
        .ev      (ev_w),
        .rd_byte (rd_byte_w),
        .held    (held_w),
        .rd_addr (rd_addr_w),
        .tick    (tick_w),
        .ack     (ack_w),
        .cmd     (cmd_w)
    );

    twe_array #(
        .AW (AWID),
        .DW (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (init_en),
        .wr_addr (init_addr),
        .wr_byte (init_byte),
        .rd_addr (rd_addr_w),
        .rd_byte (rd_byte_w)
    );

endmodule

// File: rtl/twe_checker.sv
module twe_checker #(
    parameter int DW       = 8,
    parameter int TW       = 5,
    parameter int CMD_END  = 9,
    parameter int ADDR_END = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          upd,
    input logic          scl,
    input logic          sda,
    input logic          line_q,
    input logic          prev_scl,
    input logic [TW-1:0] tick,
    input logic          ack,
    input logic [DW-1:0] cmd
);

    localparam logic [TW-1:0] T_ONE       = TW'(1);
    localparam logic [TW-1:0] T_CMD_END   = TW'(CMD_END);
    localparam logic [TW-1:0] T_CMD_LAST  = TW'(CMD_END - 1);
    localparam logic [TW-1:0] T_ADDR_LAST = TW'(ADDR_END - 1);

    logic rise, cond;
    assign rise = !prev_scl && scl;
    assign cond = prev_scl && scl && (line_q != sda);

    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        upd && prev_scl && scl && line_q && !sda |=> tick == T_ONE && cmd == '0);

    p_hunt_holds_r3: assert property (@(posedge clk) disable iff (rst)
        upd && tick == '0 && !ack && !cond |=> tick == '0 && !ack && $stable(cmd));

    p_slip_no_bit_r4: assert property (@(posedge clk) disable iff (rst)
        upd && !ack && tick != '0 && rise && line_q != sda |=> $stable(tick) && $stable(cmd));

    p_ack_drives_low_r5: assert property (@(posedge clk) disable iff (rst)
        upd && ack && rise |=> !ack && !line_q);

    p_cmd_end_r6: assert property (@(posedge clk) disable iff (rst)
        upd && !ack && tick == T_CMD_LAST && rise && line_q == sda
        |=> ack && tick == T_CMD_END && cmd[0] == $past(sda));

    p_addr_end_r7: assert property (@(posedge clk) disable iff (rst)
        upd && !ack && tick == T_ADDR_LAST && rise && line_q == sda |=> ack && tick == '0);

    p_quiet_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(line_q) && $stable(tick) && $stable(ack) && $stable(cmd));

endmodule

bind twire_eeprom_target twe_checker #(
    .DW       (DATA_W),
    .TW       (TICK_W),
    .CMD_END  (CMD_END),
    .ADDR_END (ADDR_END)
) u_twe_checker (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd_stb),
    .scl      (upd_scl),
    .sda      (upd_sda),
    .line_q   (sda_level),
    .prev_scl (held_scl_w),
    .tick     (tick_w),
    .ack      (ack_w),
    .cmd      (cmd_w)
);

// File: tb/test_twire_eeprom_target.sv
module test_twire_eeprom_target;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_stb = 1'b0;
    logic       upd_scl = 1'b1;
    logic       upd_sda = 1'b1;
    logic       sda_level;
    logic       init_en = 1'b0;
    logic [7:0] init_addr = '0;
    logic [7:0] init_byte = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    twire_eeprom_target i_twire_eeprom_target (
        .clk       (clk),
        .rst       (rst),
        .upd_stb   (upd_stb),
        .upd_scl   (upd_scl),
        .upd_sda   (upd_sda),
        .sda_level (sda_level),
        .init_en   (init_en),
        .init_addr (init_addr),
        .init_byte (init_byte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        upd_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one sample pair; output is valid when the task returns
    task automatic step(input logic s, input logic d);
        @(negedge clk);
        upd_stb = 1'b1;
        upd_scl = s;
        upd_sda = d;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic start_cond();
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
    endtask

    task automatic send_bit(input logic b, input logic expv, input string req);
        step(1'b0, b);
        step(1'b1, b);
        chk(req, {7'b0, sda_level}, {7'b0, expv});
    endtask

    task automatic send_byte(input logic [7:0] host, input logic [7:0] expv, input string req);
        for (int i = 7; i >= 0; i--) begin
            send_bit(host[i], expv[i], req);
        end
    endtask

    task automatic ack_slot(input logic expv, input string req);
        send_bit(1'b1, expv, req);
    endtask

    task automatic init_write(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        init_en = 1'b1;
        init_addr = a;
        init_byte = b;
        @(negedge clk);
        init_en = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk("R1 reset level", {7'b0, sda_level}, 8'h01);
    endtask

    // R3: bits without a start are ignored, no acknowledge appears
    task automatic t_idle();
        send_byte(8'hA6, 8'hA6, "R3 idle echo");
        ack_slot(1'b1, "R3 no ack without start");
    endtask

    // R6 R7 R8 R9: write command and address, echo and acknowledges
    task automatic t_write_addr();
        init_write(8'h12, 8'h77);
        start_cond();
        send_byte(8'hA0, 8'hA0, "R9 cmd echo");
        ack_slot(1'b0, "R6 R5 cmd ack");
        send_byte(8'h12, 8'h12, "R8 write addr echo");
        ack_slot(1'b0, "R7 addr ack");
        send_bit(1'b1, 1'b1, "R7 back to idle");
    endtask

    // R10 R8 R6: preload, select address, read back in later transfers
    task automatic t_read();
        init_write(8'h3C, 8'hA5);
        init_write(8'h00, 8'h5A);
        start_cond();
        send_byte(8'hA0, 8'hA0, "R9 cmd echo");
        ack_slot(1'b0, "R5 ack");
        send_byte(8'h3C, 8'h3C, "R8 write addr echo");
        ack_slot(1'b0, "R7 ack");
        start_cond();
        send_byte(8'hA1, 8'hA1, "R6 read cmd echo");
        ack_slot(1'b0, "R6 read ack");
        send_byte(8'h00, 8'hA5, "R10 R8 read byte 3C");
        ack_slot(1'b0, "R7 ack after read");
        start_cond();
        send_byte(8'hA1, 8'hA1, "R6 read cmd echo");
        ack_slot(1'b0, "R6 read ack");
        send_byte(8'hFF, 8'h5A, "R10 R8 read byte 00");
        ack_slot(1'b0, "R7 ack after read");
    endtask

    // R4: a rising update with changed data takes no bit
    task automatic t_slip();
        start_cond();
        send_bit(1'b1, 1'b1, "R4 bit");
        send_bit(1'b0, 1'b0, "R4 bit");
        send_bit(1'b1, 1'b1, "R4 bit");
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        chk("R4 R9 slip level", {7'b0, sda_level}, 8'h00);
        for (int i = 0; i < 5; i++) begin
            send_bit(1'b0, 1'b0, "R4 bit after slip");
        end
        ack_slot(1'b0, "R4 ack after 8 good bits");
    endtask

    // R2: a start mid command restarts the count
    task automatic t_restart();
        start_cond();
        send_bit(1'b1, 1'b1, "R2 bit");
        send_bit(1'b1, 1'b1, "R2 bit");
        send_bit(1'b1, 1'b1, "R2 bit");
        start_cond();
        send_byte(8'hA8, 8'hA8, "R2 restart count");
        ack_slot(1'b0, "R2 ack after restart");
    endtask

    // R2: a stop does not reset the count
    task automatic t_stop();
        start_cond();
        send_bit(1'b1, 1'b1, "R2 bit");
        send_bit(1'b0, 1'b0, "R2 bit");
        send_bit(1'b1, 1'b1, "R2 bit");
        send_bit(1'b0, 1'b0, "R2 bit");
        send_bit(1'b0, 1'b0, "R2 bit before stop");
        step(1'b1, 1'b1);
        chk("R2 stop level", {7'b0, sda_level}, 8'h01);
        send_bit(1'b0, 1'b0, "R2 bit after stop");
        send_bit(1'b0, 1'b0, "R2 bit after stop");
        send_bit(1'b0, 1'b0, "R2 bit after stop");
        ack_slot(1'b0, "R2 stop keeps count");
    endtask

    // R11: strobe low changes nothing
    task automatic t_quiet();
        start_cond();
        send_byte(8'hA0, 8'hA0, "R9 cmd echo");
        @(negedge clk);
        upd_scl = 1'b0; upd_sda = 1'b1;
        @(negedge clk);
        upd_scl = 1'b1; upd_sda = 1'b1;
        @(negedge clk);
        upd_scl = 1'b1; upd_sda = 1'b0;
        @(negedge clk);
        chk("R11 level held", {7'b0, sda_level}, 8'h00);
        ack_slot(1'b0, "R11 ack still pending");
    endtask

    // R1: reset mid transfer clears pending acknowledge and count
    task automatic t_reset_mid();
        start_cond();
        send_byte(8'hA0, 8'hA0, "R9 cmd echo");
        do_reset();
        chk("R1 level after reset", {7'b0, sda_level}, 8'h01);
        send_byte(8'h3C, 8'h3C, "R1 idle after reset");
        ack_slot(1'b1, "R1 no ack after reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_write_addr();
        t_read();
        t_slip();
        t_restart();
        t_stop();
        t_quiet();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule